// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block moves a block of words between one peripheral and memory while the processor does other work. Software sets a start address, a word count and a channel configuration through a small register port, then sets the start bit. The engine asks a bus arbiter for the bus. Once the arbiter grants it, the engine performs one memory write or one memory read per device-ready cycle. When the last word has moved, it raises an interrupt.

Three occupancy policies are available. The block policy keeps the bus from the first grant until the last word. The stealing policy takes one bus cycle for each word and gives the bus back between words. The idle-slot policy holds the request but moves a word only in cycles that the processor marks as unused. Each transfer is a single cycle in which the memory strobe, the memory address and the device acknowledge are valid together.

Register map (2-bit select): 0 = address, 1 = word count, 2 = configuration (bit 0 direction, bits 2:1 policy, bit 3 start, which is write-only), 3 = status (read: bit 0 busy, bit 1 interrupt; write: bit 1 set to 1 clears the interrupt).

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After reset, bus_req, irq, mem_we, mem_re and dev_ack are low, and all four registers read back as zero.
- R2: Writes to address, count and configuration take effect only while the channel is idle. While busy, these writes and any start bit are ignored. The configuration reads back as {policy, direction} in bits 2:0.
- R3: Setting start with a non-zero count raises bus_req. mem_we, mem_re and dev_ack are asserted only in cycles where both bus_req and bus_grant are high.
- R4: Each transfer uses the current address on mem_addr. In the following cycle the address has increased by one and the count has decreased by one.
- R5: Direction 0 (device to memory) asserts mem_we with mem_wdata equal to dev_rdata. Direction 1 (memory to device) asserts mem_re with dev_wdata equal to mem_rdata. The two strobes are never high together.
- R6: Block policy (bits 2:1 = 0) keeps bus_req high without a break from start until the last word.
- R7: Stealing policy (bits 2:1 = 1) moves one word per request. bus_req is low in the cycle after each word and rises again only after dev_ready is seen.
- R8: Idle-slot policy (bits 2:1 = 2) moves a word only in a cycle where cpu_idle is high.
- R9: irq is high from the cycle after the last word, rises once per block, and bus_req is low in that cycle.
- R10: Starting with a count of zero raises irq in the next cycle and never raises bus_req.
- R11: irq stays high until a status write with bit 1 set. A status write with bit 1 clear leaves it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | REG_W (16) | Register write data |
| reg_rdata | output | REG_W (16) | Register read data (combinational) |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Bus grant from the arbiter |
| cpu_idle | input | 1 | Processor does not need the bus this cycle |
| dev_ready | input | 1 | Device can supply or accept a word |
| dev_rdata | input | DATA_W (16) | Word from the device |
| dev_wdata | output | DATA_W (16) | Word to the device |
| dev_ack | output | 1 | A word moves this cycle |
| mem_addr | output | ADDR_W (16) | Memory address, zero outside transfer cycles |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | DATA_W (16) | Memory write data |
| mem_rdata | input | DATA_W (16) | Memory read data, same cycle |
| irq | output | 1 | Completion interrupt |

## Verification
The block policy is run with a device that is ready only every other cycle, so stalls inside a held bus can be told apart from a released bus. The stealing policy is run memory-to-device behind an arbiter that grants one cycle late, which shows whether the request really drops and rises again for each word. The idle-slot policy is run with cpu_idle high one cycle in three, so any transfer made in a busy processor cycle shows up. A zero-count start and a series of writes made while the grant is withheld cover the immediate interrupt and the writes that must be ignored during a block.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int unsigned REG_SEL_W = 2;
    localparam int unsigned CTRL_W    = 4;

    localparam logic [REG_SEL_W-1:0] SEL_ADDR   = 2'd0;
    localparam logic [REG_SEL_W-1:0] SEL_COUNT  = 2'd1;
    localparam logic [REG_SEL_W-1:0] SEL_CTRL   = 2'd2;
    localparam logic [REG_SEL_W-1:0] SEL_STATUS = 2'd3;

    localparam int unsigned START_BIT = 3;
    localparam int unsigned CLR_BIT   = 1;

    typedef enum logic [1:0] {
        MODE_BURST  = 2'd0,
        MODE_STEAL  = 2'd1,
        MODE_TRANSP = 2'd2,
        MODE_RSVD   = 2'd3
    } xfer_mode_e;

    typedef enum logic {
        DIR_DEV2MEM = 1'b0,
        DIR_MEM2DEV = 1'b1
    } xfer_dir_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_DEV = 2'd1,
        ST_REQ      = 2'd2,
        ST_OWN      = 2'd3
    } seq_state_e;

    typedef struct packed {
        xfer_mode_e mode;
        xfer_dir_e  dir;
    } chan_cfg_t;

    typedef struct packed {
        logic start;
        logic clr_irq;
        logic ld_addr;
        logic ld_count;
        logic ld_cfg;
    } reg_cmd_t;

    // Policies other than stealing keep the request between words.
    function automatic logic keeps_bus(input xfer_mode_e m);
        return (m != MODE_STEAL);
    endfunction

    // Idle-slot policy needs a free processor cycle; others do not.
    function automatic logic slot_open(input xfer_mode_e m, input logic cpu_free);
        return (m != MODE_TRANSP) || cpu_free;
    endfunction

    function automatic chan_cfg_t unpack_cfg(input logic [2:0] bits);
        chan_cfg_t c;
        c.mode = xfer_mode_e'(bits[2:1]);
        c.dir  = xfer_dir_e'(bits[0]);
        return c;
    endfunction

endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_SEL_W-1:0] wr_sel,
    input  logic [CTRL_W-1:0]    wr_bits,
    input  logic                 busy,
    input  logic                 done,
    output reg_cmd_t             cmd,
    output chan_cfg_t            cfg_q,
    output chan_cfg_t            cfg_next,
    output logic                 irq_q
);

    always_comb begin
        cmd          = '0;
        cmd.ld_addr  = wr_en && !busy && (wr_sel == SEL_ADDR);
        cmd.ld_count = wr_en && !busy && (wr_sel == SEL_COUNT);
        cmd.ld_cfg   = wr_en && !busy && (wr_sel == SEL_CTRL);
        cmd.start    = cmd.ld_cfg && wr_bits[START_BIT];
        cmd.clr_irq  = wr_en && (wr_sel == SEL_STATUS) && wr_bits[CLR_BIT];
    end

    // Configuration seen by the sequencer in the cycle of a start write.
    assign cfg_next = cmd.ld_cfg ? unpack_cfg(wr_bits[2:0]) : cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{mode: MODE_BURST, dir: DIR_DEV2MEM};
        end else if (cmd.ld_cfg) begin
            cfg_q <= unpack_cfg(wr_bits[2:0]);
        end
    end

    // Completion wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (done) begin
            irq_q <= 1'b1;
        end else if (cmd.clr_irq) begin
            irq_q <= 1'b0;
        end
    end

    p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_q));

    p_irq_set_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> irq_q);

    p_irq_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !cmd.clr_irq) |=> irq_q);

endmodule

// File: rtl/dma_ptr.sv
module dma_ptr #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_addr,
    input  logic              ld_count,
    input  logic [REG_W-1:0]  wdata,
    input  logic              step,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              cnt_zero,
    output logic              cnt_last
);

    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    // The programmed registers are also the working pointers.
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (ld_addr) begin
            addr_q <= wdata[ADDR_W-1:0];
        end else if (step) begin
            addr_q <= addr_q + ADDR_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ld_count) begin
            cnt_q <= wdata[CNT_W-1:0];
        end else if (step) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    assign cnt_zero = (cnt_q == '0);
    assign cnt_last = (cnt_q == CNT_ONE);

    p_step_move_r4: assert property (@(posedge clk) disable iff (rst)
        step |=> (addr_q == $past(addr_q) + ADDR_ONE) && (cnt_q == $past(cnt_q) - CNT_ONE));

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        step |-> !cnt_zero);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      cnt_zero,
    input  logic      cnt_last,
    input  chan_cfg_t cfg_q,
    input  chan_cfg_t start_cfg,
    input  logic      bus_grant,
    input  logic      dev_ready,
    input  logic      cpu_idle,
    output logic      bus_req,
    output logic      xfer,
    output logic      done,
    output logic      busy
);

    seq_state_e state, state_nx;

    always_comb begin
        busy    = (state != ST_IDLE);
        bus_req = (state == ST_REQ) || (state == ST_OWN);
        xfer    = (state == ST_OWN) && bus_grant && dev_ready
                  && slot_open(cfg_q.mode, cpu_idle);
        done    = ((state == ST_IDLE) && start && cnt_zero) || (xfer && cnt_last);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start && !cnt_zero) begin
                    state_nx = keeps_bus(start_cfg.mode) ? ST_REQ : ST_WAIT_DEV;
                end
            end
            ST_WAIT_DEV: begin
                if (dev_ready) state_nx = ST_REQ;
            end
            ST_REQ: begin
                if (bus_grant) state_nx = ST_OWN;
            end
            ST_OWN: begin
                if (xfer) begin
                    if (cnt_last)                    state_nx = ST_IDLE;
                    else if (!keeps_bus(cfg_q.mode)) state_nx = ST_WAIT_DEV;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    p_strobe_grant_r3: assert property (@(posedge clk) disable iff (rst)
        xfer |-> (bus_grant && bus_req));

    p_burst_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_req && (cfg_q.mode == MODE_BURST) && !done) |=> bus_req);

    p_steal_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (xfer && (cfg_q.mode == MODE_STEAL)) |=> !bus_req);

    p_idle_slot_r8: assert property (@(posedge clk) disable iff (rst)
        (xfer && (cfg_q.mode == MODE_TRANSP)) |-> cpu_idle);

    p_done_release_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !bus_req);

    p_zero_start_r10: assert property (@(posedge clk) disable iff (rst)
        (start && cnt_zero) |=> (!busy && !bus_req));

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
    import dma_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned REG_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [REG_SEL_W-1:0] reg_sel,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 bus_req,
    input  logic                 bus_grant,
    input  logic                 cpu_idle,
    input  logic                 dev_ready,
    input  logic [DATA_W-1:0]    dev_rdata,
    output logic [DATA_W-1:0]    dev_wdata,
    output logic                 dev_ack,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_we,
    output logic                 mem_re,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 irq
);

    reg_cmd_t          cmd;
    chan_cfg_t         cfg_q, cfg_next;
    logic              irq_q, busy, done, xfer;
    logic              cnt_zero, cnt_last;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;

    dma_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_we),
        .wr_sel   (reg_sel),
        .wr_bits  (reg_wdata[CTRL_W-1:0]),
        .busy     (busy),
        .done     (done),
        .cmd      (cmd),
        .cfg_q    (cfg_q),
        .cfg_next (cfg_next),
        .irq_q    (irq_q)
    );

    dma_ptr #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .REG_W  (REG_W)
    ) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .ld_addr  (cmd.ld_addr),
        .ld_count (cmd.ld_count),
        .wdata    (reg_wdata),
        .step     (xfer),
        .addr_q   (addr_q),
        .cnt_q    (cnt_q),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last)
    );

    dma_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (cmd.start),
        .cnt_zero  (cnt_zero),
        .cnt_last  (cnt_last),
        .cfg_q     (cfg_q),
        .start_cfg (cfg_next),
        .bus_grant (bus_grant),
        .dev_ready (dev_ready),
        .cpu_idle  (cpu_idle),
        .bus_req   (bus_req),
        .xfer      (xfer),
        .done      (done),
        .busy      (busy)
    );

    // Bus-side outputs stay at zero outside a granted transfer cycle.
    always_comb begin
        mem_we    = xfer && (cfg_q.dir == DIR_DEV2MEM);
        mem_re    = xfer && (cfg_q.dir == DIR_MEM2DEV);
        mem_addr  = xfer ? addr_q : '0;
        mem_wdata = mem_we ? dev_rdata : '0;
        dev_wdata = mem_re ? mem_rdata : '0;
        dev_ack   = xfer;
        irq       = irq_q;
    end

    always_comb begin
        unique case (reg_sel)
            SEL_ADDR:   reg_rdata = REG_W'(addr_q);
            SEL_COUNT:  reg_rdata = REG_W'(cnt_q);
            SEL_CTRL:   reg_rdata = REG_W'(cfg_q);
            SEL_STATUS: reg_rdata = REG_W'({irq_q, busy});
            default:    reg_rdata = '0;
        endcase
    end

    p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

endmodule

// File: tb/dma_xfer_ctrl_tb.sv
module dma_xfer_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [1:0]  reg_sel;
    logic [15:0] reg_wdata, reg_rdata;
    logic        bus_req, bus_grant, cpu_idle, dev_ready, dev_ack;
    logic [15:0] dev_rdata, dev_wdata, mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, mem_re, irq;

    logic [15:0] mem [0:63];
    logic [15:0] sink [$];
    int          src_idx;
    int          n_chk, n_fail;
    int          req_rise, req_fall, irq_rise, bad_slot;
    logic        prev_req, prev_irq, last_req, grant_en;

    // reference model state
    int          m_ph, m_mode;
    logic [15:0] m_addr, m_cnt;
    logic        m_dir, m_irq;

    always #5ns clk = ~clk;   // 100 MHz

    assign mem_rdata = mem[mem_addr[5:0]];
    assign dev_rdata = 16'hA000 + src_idx[15:0];

    dma_xfer_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
        .bus_grant(bus_grant), .cpu_idle(cpu_idle), .dev_ready(dev_ready),
        .dev_rdata(dev_rdata), .dev_wdata(dev_wdata), .dev_ack(dev_ack),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic model_update(input logic x);
        int   ph0;
        logic fin;
        ph0 = m_ph;
        fin = 1'b0;
        if (ph0 == 0) begin
            if (reg_we) begin
                case (reg_sel)
                    2'd0: m_addr = reg_wdata;
                    2'd1: m_cnt  = reg_wdata;
                    2'd2: begin
                        m_dir  = reg_wdata[0];
                        m_mode = int'(reg_wdata[2:1]);
                        if (reg_wdata[3]) begin
                            if (m_cnt == 0) fin = 1'b1;
                            else            m_ph = (m_mode == 1) ? 1 : 2;
                        end
                    end
                    default: ;
                endcase
            end
        end else if (ph0 == 1) begin
            if (dev_ready) m_ph = 2;
        end else if (ph0 == 2) begin
            if (bus_grant) m_ph = 3;
        end else if (x) begin
            m_addr = m_addr + 16'd1;
            m_cnt  = m_cnt - 16'd1;
            if (m_cnt == 0) begin
                m_ph = 0;
                fin  = 1'b1;
            end else if (m_mode == 1) begin
                m_ph = 1;
            end
        end
        if (fin) m_irq = 1'b1;
        else if (reg_we && reg_sel == 2'd3 && reg_wdata[1]) m_irq = 1'b0;
    endtask

    // One clock: compare against the model, cross the edge, update the model.
    task automatic step();
        logic        ex, ewe, ere, c_we, c_re;
        logic [15:0] eaddr, c_addr, c_wd, c_dw;
        logic [63:0] act, exp;
        #1ns;
        ex    = (m_ph == 3) && bus_grant && dev_ready && (m_mode != 2 || cpu_idle);
        ewe   = ex && !m_dir;
        ere   = ex && m_dir;
        eaddr = ex ? m_addr : 16'h0;
        exp   = 64'({m_ph >= 2, m_irq, ewe, ere, ex, eaddr});
        act   = 64'({bus_req, irq, mem_we, mem_re, dev_ack, mem_addr});
        chk(act == exp, "R3 R4 R6 R7 R8 R9", "cycle model {req,irq,we,re,ack,addr}", act, exp);
        if (ewe) chk(mem_wdata == dev_rdata, "R5", "mem_wdata", 64'(mem_wdata), 64'(dev_rdata));
        if (ere) chk(dev_wdata == mem[m_addr[5:0]], "R5", "dev_wdata",
                     64'(dev_wdata), 64'(mem[m_addr[5:0]]));
        if (bus_req && !prev_req) req_rise++;
        if (!bus_req && prev_req) req_fall++;
        if (irq && !prev_irq) irq_rise++;
        if (dev_ack && !cpu_idle) bad_slot++;
        prev_req = bus_req;
        prev_irq = irq;
        last_req = bus_req;
        c_we = mem_we; c_re = mem_re; c_addr = mem_addr; c_wd = mem_wdata; c_dw = dev_wdata;
        @(posedge clk);
        model_update(ex);
        if (c_we) begin
            mem[c_addr[5:0]] = c_wd;
            src_idx++;
        end
        if (c_re) sink.push_back(c_dw);
        @(negedge clk);
        bus_grant = grant_en && last_req;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_sel = a; reg_wdata = d;
        step();
        reg_we = 1'b0; reg_wdata = 16'h0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] e, input string rq);
        reg_sel = a;
        #1ns;
        chk(reg_rdata == e, rq, $sformatf("register %0d readback", a), 64'(reg_rdata), 64'(e));
    endtask

    task automatic run(input int rp, input int ip, input int maxc);
        for (int k = 0; k < maxc; k++) begin
            dev_ready = (k % rp) == 0;
            cpu_idle  = (k % ip) == 0;
            step();
            if (m_ph == 0) break;
        end
        dev_ready = 1'b0;
        cpu_idle  = 1'b0;
        step();
    endtask

    task automatic clear_stats();
        req_rise = 0; req_fall = 0; irq_rise = 0; bad_slot = 0;
    endtask

    initial begin
        #1ms;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion before timeout");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int s;
        n_chk = 0; n_fail = 0; src_idx = 0;
        rst = 1'b1; reg_we = 1'b0; reg_sel = 2'd0; reg_wdata = 16'h0;
        bus_grant = 1'b0; cpu_idle = 1'b0; dev_ready = 1'b0; grant_en = 1'b1;
        prev_req = 1'b0; prev_irq = 1'b0; last_req = 1'b0;
        m_ph = 0; m_mode = 0; m_addr = 16'h0; m_cnt = 16'h0; m_dir = 1'b0; m_irq = 1'b0;
        for (int i = 0; i < 64; i++) mem[i] = 16'h5000 + 16'(i);
        clear_stats();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1ns;
        chk({bus_req, irq, mem_we, mem_re, dev_ack} == 5'b0, "R1", "outputs after reset",
            64'({bus_req, irq, mem_we, mem_re, dev_ack}), 64'h0);
        for (int a = 0; a < 4; a++) rd(2'(a), 16'h0, "R1");
        step();

        // Block policy, device to memory, device ready every other cycle
        wr(2'd0, 16'h0010);
        wr(2'd1, 16'd4);
        rd(2'd1, 16'd4, "R2");
        clear_stats();
        s = src_idx;
        wr(2'd2, 16'h0008);
        run(2, 1, 200);
        chk(req_rise == 1 && req_fall == 1, "R6", "request edges in block policy",
            64'({req_rise[15:0], req_fall[15:0]}), 64'h0001_0001);
        rd(2'd0, 16'h0014, "R4");
        rd(2'd1, 16'h0000, "R4");
        chk(irq && irq_rise == 1, "R9", "single completion interrupt", 64'(irq_rise), 64'd1);
        for (int i = 0; i < 4; i++)
            chk(mem[16 + i] == 16'hA000 + 16'(s + i), "R5", "device-to-memory word",
                64'(mem[16 + i]), 64'(16'hA000 + 16'(s + i)));

        // R11 interrupt hold and clear
        wr(2'd3, 16'h0001);
        #1ns;
        chk(irq == 1'b1, "R11", "irq after write without clear bit", 64'(irq), 64'd1);
        wr(2'd3, 16'h0002);
        #1ns;
        chk(irq == 1'b0, "R11", "irq after clear write", 64'(irq), 64'd0);
        rd(2'd3, 16'h0000, "R11");

        // Stealing policy, memory to device
        wr(2'd0, 16'h0020);
        wr(2'd1, 16'd3);
        clear_stats();
        sink.delete();
        wr(2'd2, 16'h000B);
        run(1, 1, 200);
        chk(req_rise == 3, "R7", "one request per word", 64'(req_rise), 64'd3);
        chk(sink.size() == 3, "R5", "words delivered to device", 64'(sink.size()), 64'd3);
        for (int i = 0; i < 3 && i < sink.size(); i++)
            chk(sink[i] == 16'h5020 + 16'(i), "R5", "memory-to-device word",
                64'(sink[i]), 64'(16'h5020 + 16'(i)));
        rd(2'd2, 16'h0003, "R2");
        chk(irq_rise == 1, "R9", "single completion interrupt", 64'(irq_rise), 64'd1);
        wr(2'd3, 16'h0002);

        // Idle-slot policy, processor free one cycle in three
        wr(2'd0, 16'h0030);
        wr(2'd1, 16'd3);
        clear_stats();
        s = src_idx;
        wr(2'd2, 16'h000C);
        run(1, 3, 300);
        chk(bad_slot == 0, "R8", "transfers in busy processor cycles", 64'(bad_slot), 64'd0);
        for (int i = 0; i < 3; i++)
            chk(mem[48 + i] == 16'hA000 + 16'(s + i), "R8", "idle-slot word",
                64'(mem[48 + i]), 64'(16'hA000 + 16'(s + i)));
        wr(2'd3, 16'h0002);

        // R10 zero-count start
        wr(2'd1, 16'd0);
        clear_stats();
        wr(2'd2, 16'h0008);
        #1ns;
        chk(irq == 1'b1, "R10", "irq after zero-count start", 64'(irq), 64'd1);
        repeat (3) step();
        chk(req_rise == 0, "R10", "no request for zero count", 64'(req_rise), 64'd0);
        rd(2'd3, 16'h0002, "R10");
        wr(2'd3, 16'h0002);

        // R2 writes while busy are ignored (grant withheld)
        grant_en = 1'b0;
        wr(2'd0, 16'h0038);
        wr(2'd1, 16'd2);
        wr(2'd2, 16'h0008);
        wr(2'd0, 16'h003F);
        wr(2'd1, 16'd9);
        wr(2'd2, 16'h000B);
        rd(2'd0, 16'h0038, "R2");
        rd(2'd1, 16'h0002, "R2");
        rd(2'd2, 16'h0000, "R2");
        rd(2'd3, 16'h0001, "R2");
        grant_en = 1'b1;
        clear_stats();
        s = src_idx;
        run(1, 1, 100);
        for (int i = 0; i < 2; i++)
            chk(mem[56 + i] == 16'hA000 + 16'(s + i), "R2", "block after ignored writes",
                64'(mem[56 + i]), 64'(16'hA000 + 16'(s + i)));
        rd(2'd0, 16'h003A, "R4");
        chk(irq_rise == 1, "R9", "single completion interrupt", 64'(irq_rise), 64'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule